// File: doc/BRIEF.md
# SPI Serial-SRAM Word Burst Engine

This block moves a run of 32-bit words between a word-wide local buffer and an external serial SRAM reached over SPI. A request names a direction, a byte address in memory, a starting slot in the local buffer and a word count. The engine lowers chip select and sends a one-byte command followed by the start address. It then streams the data bytes while the memory steps its own address in sequential mode. After the last word it raises chip select again and pulses `done`.

Each request also picks the byte order of the words on the serial bus. With little-endian packing the least significant byte goes to the lowest memory address. With legacy big-endian packing the word is shifted as one 32-bit value, most significant bit first. One address bit routes a request to a separate flash region. There, reads are handed off through a strobe and writes are dropped without any bus traffic.

Top module: `spi_word_burst`

## Requirements
- R1: Every SRAM burst begins with chip select low and 8 command bits, 0x03 for a read or 0x02 for a write. The low ADDR_BITS bits of the request address follow, MSB first, before any data bit.
- R2: The address is sent once per burst, in a single chip-select frame. Word k of the burst occupies memory bytes addr+4k to addr+4k+3.
- R3: With `req_le`=1, memory byte addr+4k+j holds bits [8j+7:8j] of word k.
- R4: With `req_le`=0, memory byte addr+4k+j holds bits [31-8j:24-8j] of word k, so the whole word is shifted out MSB first.
- R5: The bus uses SPI mode 0. `spi_sclk` is low whenever chip select is high. `spi_mosi` changes only while `spi_sclk` is low, and every byte travels MSB first.
- R6: On a read with `req_le`=1, the first byte received becomes bits 7:0 and the fourth becomes bits 31:24. Reading back in the mode used for writing returns the original words.
- R7: Word k of a burst is taken from or stored to local buffer slot `req_buf`+k. No other slot is written.
- R8: `busy` is high and chip select stays low for the whole burst. After the last word, chip select rises and `done` pulses for exactly one cycle while chip select is high.
- R9: A write whose address has bit 20 set produces `done` without any chip-select or clock activity and leaves memory unchanged.
- R10: A read whose address has bit 20 set pulses `flash_req` for one cycle, with `flash_addr` and `flash_count` equal to the request. SRAM chip select is not driven.
- R11: A request with a count of 0 produces `done` with no bus activity.
- R12: `spi_sclk` rises once every 2*CLK_DIV system clock cycles within a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, taken when idle |
| req_write | input | 1 | 1 = buffer to memory, 0 = memory to buffer |
| req_le | input | 1 | 1 = little-endian byte packing, 0 = big-endian |
| req_addr | input | REQ_AW | Memory byte address; bit 20 selects the flash region |
| req_buf | input | BUF_AW | First local buffer slot |
| req_count | input | CNT_W | Number of words |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |
| buf_raddr | output | BUF_AW | Local buffer read slot |
| buf_rdata | input | 32 | Local buffer read data (combinational) |
| buf_we | output | 1 | Local buffer write enable |
| buf_waddr | output | BUF_AW | Local buffer write slot |
| buf_wdata | output | 32 | Local buffer write data |
| flash_req | output | 1 | Flash read hand-off strobe |
| flash_addr | output | REQ_AW | Address carried with the hand-off |
| flash_count | output | CNT_W | Word count carried with the hand-off |
| spi_cs_n | output | 1 | SRAM chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |

## Verification
The bench sweeps both byte orders, all four byte offsets of the start address and bursts of one to four words, and reads back every burst into fresh buffer slots. An engine that swapped the byte order, or shifted LSB first, would leave the wrong bytes in the memory model. An engine that resent the address per word, or failed to step the buffer pointer, would duplicate or misplace words, or overwrite a sentinel slot. Flash-region writes, flash reads and zero-count requests are each checked for silence on chip select and clock. A design that ignored bit 20 or the zero count would open a frame or corrupt memory.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_END  = 2'd3
  } burst_state_t;

  // Reverse the four bytes of a word.
  function automatic logic [31:0] swap_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Word as it must be shifted (MSB first) for the chosen packing.
  function automatic logic [31:0] wire_order(input logic [31:0] w, input logic le);
    return le ? swap_bytes(w) : w;
  endfunction

  // Command byte and address, left aligned in a 32-bit shift value.
  function automatic logic [31:0] header_word(input logic [7:0] cmd,
                                              input logic [31:0] addr,
                                              input int abits);
    logic [31:0] mask;
    mask = (32'h1 << abits) - 32'h1;
    return {cmd, 24'h0} | ((addr & mask) << (24 - abits));
  endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(DIV - 1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || at_end)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R12
    end
  endgenerate

endmodule

// File: rtl/spi_shift32.sv
module spi_shift32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] load_val,
  input  logic        rise,
  input  logic        fall,
  input  logic        miso,
  output logic        mosi,
  output logic [31:0] rx
);
  logic [31:0] tx;

  assign mosi = tx[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx <= '0;
    else if (load)  tx <= load_val;
    else if (fall)  tx <= {tx[30:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx <= '0;
    else if (rise)  rx <= {rx[30:0], miso};
  end

  AST_NO_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !rise); // R5

endmodule

// File: rtl/spi_word_burst.sv
module spi_word_burst
  import spi_burst_pkg::*;
#(
  parameter int         CLK_DIV   = 2,
  parameter int         ADDR_BITS = 16,
  parameter int         REQ_AW    = 24,
  parameter int         FLASH_BIT = 20,
  parameter int         CNT_W     = 8,
  parameter int         BUF_AW    = 4,
  parameter logic [7:0] CMD_READ  = 8'h03,
  parameter logic [7:0] CMD_WRITE = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_write,
  input  logic              req_le,
  input  logic [REQ_AW-1:0] req_addr,
  input  logic [BUF_AW-1:0] req_buf,
  input  logic [CNT_W-1:0]  req_count,
  output logic              busy,
  output logic              done,
  output logic [BUF_AW-1:0] buf_raddr,
  input  logic [31:0]       buf_rdata,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_waddr,
  output logic [31:0]       buf_wdata,
  output logic              flash_req,
  output logic [REQ_AW-1:0] flash_addr,
  output logic [CNT_W-1:0]  flash_count,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int HDR_BITS = 8 + ADDR_BITS;
  localparam int BIT_W    = 6;

  burst_state_t      state;
  logic              sclk_q, cs_n_q, wr_q, le_q;
  logic [BIT_W-1:0]  bits_left;
  logic [CNT_W-1:0]  words_left;
  logic [BUF_AW-1:0] ptr;
  logic              done_q, flash_req_q, we_q;
  logic [REQ_AW-1:0] flash_addr_q;
  logic [CNT_W-1:0]  flash_count_q;
  logic [BUF_AW-1:0] waddr_q;
  logic [31:0]       wdata_q;

  // Named internal events.
  logic        tick, run, rise_ev, fall_ev, word_end, last_word;
  logic        go_zero, go_flash, go_spi, accept, shift_load;
  logic [31:0] shift_val, rx_word, hdr_val;

  assign run       = (state == ST_HDR) || (state == ST_DATA);
  assign rise_ev   = tick && !sclk_q;
  assign fall_ev   = tick && sclk_q;
  assign word_end  = fall_ev && (bits_left == BIT_W'(1));
  assign last_word = (words_left == CNT_W'(1));
  assign go_zero   = (req_count == '0);
  assign go_flash  = !go_zero && req_addr[FLASH_BIT];
  assign go_spi    = !go_zero && !go_flash;
  assign accept    = (state == ST_IDLE) && start;
  assign hdr_val   = header_word(req_write ? CMD_WRITE : CMD_READ,
                                 32'(req_addr), ADDR_BITS);

  assign shift_load = (accept && go_spi) ||
                      (word_end && ((state == ST_HDR) || !last_word));
  assign shift_val  = (state == ST_IDLE) ? hdr_val :
                      (wr_q ? wire_order(buf_rdata, le_q) : 32'h0);

  spi_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  spi_shift32 u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (shift_load),
    .load_val(shift_val),
    .rise    (rise_ev),
    .fall    (fall_ev),
    .miso    (spi_miso),
    .mosi    (spi_mosi),
    .rx      (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      sclk_q        <= 1'b0;
      cs_n_q        <= 1'b1;
      wr_q          <= 1'b0;
      le_q          <= 1'b0;
      bits_left     <= '0;
      words_left    <= '0;
      ptr           <= '0;
      done_q        <= 1'b0;
      flash_req_q   <= 1'b0;
      flash_addr_q  <= '0;
      flash_count_q <= '0;
      we_q          <= 1'b0;
      waddr_q       <= '0;
      wdata_q       <= '0;
    end else begin
      done_q      <= 1'b0;
      flash_req_q <= 1'b0;
      we_q        <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (go_zero) begin
              done_q <= 1'b1;
            end else if (go_flash) begin
              done_q <= 1'b1;
              if (!req_write) begin
                flash_req_q   <= 1'b1;
                flash_addr_q  <= req_addr;
                flash_count_q <= req_count;
              end
            end else begin
              cs_n_q     <= 1'b0;
              state      <= ST_HDR;
              bits_left  <= BIT_W'(HDR_BITS);
              words_left <= req_count;
              ptr        <= req_buf;
              wr_q       <= req_write;
              le_q       <= req_le;
            end
          end
        end
        ST_HDR, ST_DATA: begin
          if (rise_ev) sclk_q <= 1'b1;
          if (fall_ev) begin
            sclk_q    <= 1'b0;
            bits_left <= bits_left - 1'b1;
          end
          if (word_end) begin
            bits_left <= BIT_W'(32);
            if (state == ST_HDR) begin
              state <= ST_DATA;
              if (wr_q) ptr <= ptr + 1'b1;
            end else begin
              if (!wr_q) begin
                we_q    <= 1'b1;
                waddr_q <= ptr;
                wdata_q <= wire_order(rx_word, le_q);
              end
              if (!wr_q || !last_word) ptr <= ptr + 1'b1;
              words_left <= words_left - 1'b1;
              if (last_word) state <= ST_END;
            end
          end
        end
        ST_END: begin
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign done        = done_q;
  assign buf_raddr   = ptr;
  assign buf_we      = we_q;
  assign buf_waddr   = waddr_q;
  assign buf_wdata   = wdata_q;
  assign flash_req   = flash_req_q;
  assign flash_addr  = flash_addr_q;
  assign flash_count = flash_count_q;
  assign spi_cs_n    = cs_n_q;
  assign spi_sclk    = sclk_q;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R5
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |=> (!spi_sclk || $stable(spi_mosi))); // R5
  AST_CS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n); // R8
  AST_FLASH_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    flash_req |-> (spi_cs_n && !busy)); // R10
  AST_WE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !wr_q); // R7

endmodule

// File: tb/spi_word_burst_bench.sv
`timescale 1ns/1ps
module spi_word_burst_bench;
  localparam int DIV = 2;
  localparam int AB  = 16;
  localparam int HB  = 8 + AB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, req_write = 1'b0, req_le = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_buf = '0;
  logic [7:0]  req_count = '0;
  logic        busy, done, buf_we, flash_req;
  logic [3:0]  buf_raddr, buf_waddr;
  logic [31:0] buf_rdata, buf_wdata;
  logic [23:0] flash_addr;
  logic [7:0]  flash_count;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  spi_word_burst #(.CLK_DIV(DIV), .ADDR_BITS(AB)) u_spi_word_burst (
    .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write),
    .req_le(req_le), .req_addr(req_addr), .req_buf(req_buf),
    .req_count(req_count), .busy(busy), .done(done),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .buf_we(buf_we),
    .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .flash_req(flash_req),
    .flash_addr(flash_addr), .flash_count(flash_count),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso));

  // Local word buffer
  logic [31:0] lbuf [16];
  assign buf_rdata = lbuf[buf_raddr];
  always @(posedge clk) if (buf_we) lbuf[buf_waddr] <= buf_wdata;

  // Behavioural serial SRAM, sequential mode
  logic [7:0]  mem [256];
  logic        prev_cs = 1'b1, prev_sclk = 1'b0;
  int          fbits = 0, rbit = 0, frames = 0, rises = 0, frise = 0;
  int          per_bad = 0, per_seen = 0;
  logic [31:0] hsh = '0;
  logic [7:0]  cmd = '0, wbyte = '0, last_cmd = '0;
  logic [7:0]  maddr = '0;
  logic [15:0] last_addr = '0;
  time         last_rise = 0;

  always @(spi_cs_n or spi_sclk) begin
    if (spi_cs_n) begin
      if (spi_sclk && !prev_sclk) rises++;
    end else if (prev_cs) begin
      frames++; fbits = 0; rbit = 0; frise = 0;
    end else if (spi_sclk && !prev_sclk) begin
      rises++;
      if (frise > 0) begin
        per_seen++;
        if (($time - last_rise) != 2 * DIV * 10) per_bad++;
      end
      last_rise = $time; frise++;
      if (fbits < HB) begin
        hsh = {hsh[30:0], spi_mosi};
        fbits++;
        if (fbits == HB) begin
          cmd = hsh[HB-1 -: 8]; last_cmd = cmd;
          last_addr = hsh[AB-1:0]; maddr = hsh[7:0];
        end
      end else begin
        if (cmd == 8'h02) begin
          wbyte = {wbyte[6:0], spi_mosi};
          if (((fbits - HB) % 8) == 7) begin mem[maddr] = wbyte; maddr = maddr + 1; end
        end
        fbits++;
      end
    end else if (!spi_sclk && prev_sclk) begin
      if (fbits >= HB && cmd == 8'h03) begin
        spi_miso = mem[maddr][7 - rbit];
        rbit++;
        if (rbit == 8) begin rbit = 0; maddr = maddr + 1; end
      end
    end
    prev_cs = spi_cs_n; prev_sclk = spi_sclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  bit          fl_seen;
  logic [23:0] fl_addr;
  logic [7:0]  fl_cnt;

  task automatic run_req(input bit wr, input bit le, input logic [23:0] a,
                         input logic [3:0] b, input logic [7:0] n);
    @(negedge clk);
    start = 1'b1; req_write = wr; req_le = le; req_addr = a; req_buf = b; req_count = n;
    @(negedge clk);
    start = 1'b0;
    fl_seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (flash_req) begin fl_seen = 1'b1; fl_addr = flash_addr; fl_cnt = flash_count; end
      if (done) break;
      @(negedge clk);
    end
    chk(done, "R8 done seen", {31'b0, done}, 32'h1);
  endtask

  // Expected byte j of word w in memory (little = low byte first)
  function automatic logic [7:0] exp_byte(input logic [31:0] w, input int j, input bit le);
    int sh;
    sh = le ? 8 * j : 8 * (3 - j);
    return 8'((w >> sh) & 32'hFF);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int f0, r0;
    logic [31:0] orig [4];
    for (int i = 0; i < 256; i++) mem[i] = 8'hA5;
    for (int i = 0; i < 16; i++) lbuf[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R8 reset cs_n", {31'b0, spi_cs_n}, 32'h1);
    chk(spi_sclk == 1'b0, "R5 reset sclk", {31'b0, spi_sclk}, 32'h0);
    chk(busy == 1'b0 && done == 1'b0, "R8 reset busy/done", {30'b0, busy, done}, 32'h0);
    rst_n = 1'b1;

    orig[0] = 32'h11223344; orig[1] = 32'h80C0E0F1; orig[2] = 32'h0102A5FE; orig[3] = 32'hCAFE1234;
    for (int k = 0; k < 3; k++) lbuf[k] = orig[k];
    lbuf[4] = orig[3]; lbuf[5] = orig[1];

    // Little-endian write, R1 R2 R3
    f0 = frames;
    run_req(1'b1, 1'b1, 24'h000010, 4'd0, 8'd3);
    chk(last_cmd == 8'h02, "R1 write command", {24'b0, last_cmd}, 32'h02);
    chk(last_addr == 16'h0010, "R1 address", {16'b0, last_addr}, 32'h10);
    chk(frames == f0 + 1, "R2 single frame", frames, f0 + 1);
    for (int k = 0; k < 3; k++)
      for (int j = 0; j < 4; j++)
        chk(mem[8'h10 + 4*k + j] == exp_byte(orig[k], j, 1'b1), "R3 LE byte",
            {24'b0, mem[8'h10 + 4*k + j]}, {24'b0, exp_byte(orig[k], j, 1'b1)});
    chk(spi_cs_n == 1'b1, "R8 cs released", {31'b0, spi_cs_n}, 32'h1);

    // Big-endian write from buffer slot 4, R4 R7
    run_req(1'b1, 1'b0, 24'h000040, 4'd4, 8'd2);
    for (int k = 0; k < 2; k++)
      for (int j = 0; j < 4; j++)
        chk(mem[8'h40 + 4*k + j] == exp_byte(lbuf[4+k], j, 1'b0), "R4 BE byte / R5 MSB first",
            {24'b0, mem[8'h40 + 4*k + j]}, {24'b0, exp_byte(lbuf[4+k], j, 1'b0)});

    // Read-back in matching modes, R6 R1
    run_req(1'b0, 1'b1, 24'h000010, 4'd8, 8'd3);
    chk(last_cmd == 8'h03, "R1 read command", {24'b0, last_cmd}, 32'h03);
    for (int k = 0; k < 3; k++) chk(lbuf[8+k] == orig[k], "R6 LE readback", lbuf[8+k], orig[k]);
    run_req(1'b0, 1'b0, 24'h000040, 4'd12, 8'd2);
    chk(lbuf[12] == orig[3], "R6 BE readback", lbuf[12], orig[3]);
    chk(lbuf[13] == orig[1], "R6 BE readback", lbuf[13], orig[1]);

    // Cross mode read: LE-written word read big-endian comes back byte-swapped, R6 R4
    run_req(1'b0, 1'b0, 24'h000010, 4'd14, 8'd1);
    chk(lbuf[14] == {orig[0][7:0], orig[0][15:8], orig[0][23:16], orig[0][31:24]},
        "R6 cross-mode swap", lbuf[14], {orig[0][7:0], orig[0][15:8], orig[0][23:16], orig[0][31:24]});

    // Flash-region write dropped, R9
    f0 = frames; r0 = rises;
    run_req(1'b1, 1'b1, 24'h100020, 4'd0, 8'd2);
    chk(frames == f0 && rises == r0, "R9 no bus activity", frames - f0 + rises - r0, 0);
    chk(!fl_seen, "R9 no flash strobe", {31'b0, fl_seen}, 0);
    chk(mem[8'h20] == 8'hA5 && mem[8'h27] == 8'hA5, "R9 memory unchanged", {24'b0, mem[8'h20]}, 32'hA5);

    // Flash-region read hand-off, R10
    f0 = frames;
    run_req(1'b0, 1'b1, 24'h100123, 4'd0, 8'd5);
    chk(fl_seen, "R10 flash strobe", {31'b0, fl_seen}, 1);
    chk(fl_addr == 24'h100123, "R10 flash address", {8'b0, fl_addr}, 32'h100123);
    chk(fl_cnt == 8'd5, "R10 flash count", {24'b0, fl_cnt}, 5);
    chk(frames == f0, "R10 no SRAM select", frames - f0, 0);

    // Zero count, R11
    f0 = frames; r0 = rises;
    run_req(1'b1, 1'b1, 24'h000030, 4'd0, 8'd0);
    run_req(1'b0, 1'b0, 24'h000030, 4'd0, 8'd0);
    chk(frames == f0 && rises == r0, "R11 zero count silent", frames - f0 + rises - r0, 0);
    chk(mem[8'h30] == 8'hA5, "R11 memory unchanged", {24'b0, mem[8'h30]}, 32'hA5);

    // Sweep: byte order x byte offset x count, R2 R3 R4 R6 R7
    for (int le = 0; le < 2; le++)
      for (int off = 0; off < 4; off++)
        for (int n = 1; n <= 4; n++) begin
          logic [7:0] base;
          base = 8'h80 + 8'(off);
          for (int k = 0; k < 4; k++)
            lbuf[k] = (32'h9E3779B9 * 32'(k + 1 + n*7 + off*3 + le*31)) ^ 32'h0F1E2D3C;
          for (int k = 8; k < 16; k++) lbuf[k] = 32'hDEAD0000 + 32'(k);
          run_req(1'b1, le[0], {16'h0, base}, 4'd0, 8'(n));
          for (int j = 0; j < 4; j++)
            chk(mem[8'(base + 4*(n-1) + j)] == exp_byte(lbuf[n-1], j, le[0]),
                le ? "R3 sweep byte" : "R4 sweep byte",
                {24'b0, mem[8'(base + 4*(n-1) + j)]}, {24'b0, exp_byte(lbuf[n-1], j, le[0])});
          run_req(1'b0, le[0], {16'h0, base}, 4'd8, 8'(n));
          for (int k = 0; k < n; k++)
            chk(lbuf[8+k] == lbuf[k], "R6 sweep readback", lbuf[8+k], lbuf[k]);
          chk(lbuf[8+n] == 32'hDEAD0000 + 32'(8+n), "R7 slot beyond count untouched",
              lbuf[8+n], 32'hDEAD0000 + 32'(8+n));
        end

    chk(per_seen > 0 && per_bad == 0, "R12 sclk period", per_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule